// File: doc/BRIEF.md
# Display window update sequencer

The sequencer drives one rectangular screen update into a display controller that takes a stream of bytes, each marked as either a command opcode or a parameter/data byte. On a start strobe it captures a rectangle given by an inclusive top-left corner (x1, y1) and an exclusive bottom-right bound (x2, y2). It then emits the column-window command (0x2A) and the row-window command (0x2B), each followed by four coordinate bytes. After those comes the memory-write command (0x2C) and the pixel payload at two bytes per pixel, high byte first. Pixels are pulled from a ready/valid source. They are taken either as native 16-bit 5-6-5 words or as 32-bit XRGB words, which the block reduces to 5-6-5.

A blank request fills the whole screen with black. It sets the window to the full panel and streams zero pixels without touching the pixel source. A normal update is accepted only while the display path is enabled. A blank is accepted in either case, so that the panel can be cleared as the path is shut down. Every byte leaves through a valid/ready handshake towards a serial link that is outside this block.

Top module: `dcs_window_seq`

## Requirements
- R1: After an accepted start the first eleven bytes are, in order: opcode 0x2A with tag 0, four bytes with tag 1, opcode 0x2B with tag 0, four bytes with tag 1, and opcode 0x2C with tag 0.
- R2: The four bytes after each window opcode are: start bits [15:8], start bits [7:0], then (bound − 1) bits [15:8] and (bound − 1) bits [7:0], computed modulo 2^16. The column window uses x1 and x2. The row window uses y1 and y2.
- R3: The payload after 0x2C has exactly 2·W·H bytes, all with tag 1, where W = x2 − x1 (0 if x2 ≤ x1) and H = y2 − y1 (0 if y2 ≤ y1). An empty rectangle ends straight after the 0x2C opcode.
- R4: Each pixel is sent as its 16-bit word, bits [15:8] first and then bits [7:0]. In native mode (fmt_xrgb = 0) the word is pix_data[15:0] and bits [31:16] are ignored.
- R5: In XRGB mode (fmt_xrgb = 1) the word is {pix_data[23:19], pix_data[15:10], pix_data[7:3]}.
- R6: A blank start uses the window (0, 0) to (SCREEN_W − 1, SCREEN_H − 1). It sends 2·SCREEN_W·SCREEN_H zero bytes and never asserts pix_ready.
- R7: A start with blank = 0 while enable = 0 is ignored: busy and out_valid stay low. A start with blank = 1 is accepted regardless of enable.
- R8: busy rises in the cycle after an accepted start and falls in the cycle after the last byte is accepted. A start while busy is ignored, and the ongoing stream and its captured inputs are unchanged.
- R9: While out_valid is high and out_ready is low, out_valid, out_dc and out_byte hold their values. A byte advances only when out_valid and out_ready are both high at a clock edge.
- R10: After reset, busy, out_valid and pix_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Display path enabled; gates non-blank updates |
| start | input | 1 | Start strobe for one update |
| blank | input | 1 | With start: full-screen zero fill |
| fmt_xrgb | input | 1 | Pixel source format: 1 = 32-bit XRGB, 0 = native 5-6-5 |
| x1 | input | 16 | First column (inclusive) |
| y1 | input | 16 | First row (inclusive) |
| x2 | input | 16 | Column bound (exclusive) |
| y2 | input | 16 | Row bound (exclusive) |
| pix_valid | input | 1 | Pixel source has a word |
| pix_data | input | 32 | Pixel word |
| pix_ready | output | 1 | Sequencer takes the pixel word this cycle |
| out_valid | output | 1 | Byte offered to the link |
| out_dc | output | 1 | Tag: 0 = command opcode, 1 = parameter/data |
| out_byte | output | 8 | Byte value |
| out_ready | input | 1 | Link accepts the byte |
| busy | output | 1 | Update in progress |

## Verification
The bench builds the block with a 20 × 12 panel. At that size a full blank payload (480 bytes) finishes in a few hundred cycles, so the blank path is checked byte by byte. Coordinates are still driven past 255, which brings non-zero high address bytes and the wrap of a zero bound within reach. Random rectangles of up to 5 × 4 pixels, together with random stalls on both the pixel source and the link, exercise the hold behaviour and the bubble between pixels.

// File: rtl/dcs_seq_pkg.sv
package dcs_seq_pkg;
  localparam int ADDR_W   = 16;
  localparam int PIX_IN_W = 32;
  localparam int HDR_LEN  = 11;

  localparam logic [7:0] OP_COL = 8'h2A;
  localparam logic [7:0] OP_ROW = 8'h2B;
  localparam logic [7:0] OP_WR  = 8'h2C;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PIX} seq_state_e;

  typedef struct packed {
    logic       dc;
    logic [7:0] b;
  } tagged_byte_t;

  // Keep the upper bits of each colour channel of an XRGB word.
  function automatic logic [15:0] xrgb_to_565(input logic [PIX_IN_W-1:0] p);
    return {p[23:19], p[15:10], p[7:3]};
  endfunction

  // Length of a half-open interval, zero when empty.
  function automatic logic [ADDR_W-1:0] span(input logic [ADDR_W-1:0] lo,
                                             input logic [ADDR_W-1:0] hi);
    return (hi > lo) ? (hi - lo) : '0;
  endfunction

  // Header byte number idx of the window/write preamble.
  function automatic tagged_byte_t hdr_byte(input logic [3:0] idx,
                                            input logic [ADDR_W-1:0] cx0,
                                            input logic [ADDR_W-1:0] cy0,
                                            input logic [ADDR_W-1:0] cx1,
                                            input logic [ADDR_W-1:0] cy1);
    logic [ADDR_W-1:0] xe;
    logic [ADDR_W-1:0] ye;
    tagged_byte_t      t;
    xe = cx1 - ADDR_W'(1);
    ye = cy1 - ADDR_W'(1);
    case (idx)
      4'd0:    t = '{dc: 1'b0, b: OP_COL};
      4'd1:    t = '{dc: 1'b1, b: cx0[15:8]};
      4'd2:    t = '{dc: 1'b1, b: cx0[7:0]};
      4'd3:    t = '{dc: 1'b1, b: xe[15:8]};
      4'd4:    t = '{dc: 1'b1, b: xe[7:0]};
      4'd5:    t = '{dc: 1'b0, b: OP_ROW};
      4'd6:    t = '{dc: 1'b1, b: cy0[15:8]};
      4'd7:    t = '{dc: 1'b1, b: cy0[7:0]};
      4'd8:    t = '{dc: 1'b1, b: ye[15:8]};
      4'd9:    t = '{dc: 1'b1, b: ye[7:0]};
      default: t = '{dc: 1'b0, b: OP_WR};
    endcase
    return t;
  endfunction
endpackage

// File: rtl/dcs_hdr_gen.sv
module dcs_hdr_gen
  import dcs_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ack,
  input  logic [ADDR_W-1:0] cx0,
  input  logic [ADDR_W-1:0] cy0,
  input  logic [ADDR_W-1:0] cx1,
  input  logic [ADDR_W-1:0] cy1,
  output tagged_byte_t      hdr,
  output logic              last
);
  localparam int IDX_W = $clog2(HDR_LEN);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n)             idx <= '0;
    else if (load)          idx <= '0;
    else if (ack && !last)  idx <= idx + IDX_W'(1);
  end

  assign last = (idx == IDX_W'(HDR_LEN - 1));
  assign hdr  = hdr_byte(4'(idx), cx0, cy0, cx1, cy1);

  // R1: a fresh header always opens with the column-window opcode
  p_hdr_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (hdr.b == OP_COL) && !hdr.dc);

  // R1: the write opcode is the final header byte
  p_hdr_last_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (hdr.b == OP_WR) && !hdr.dc);
endmodule

// File: rtl/dcs_pix_conv.sv
module dcs_pix_conv
  import dcs_seq_pkg::*;
(
  input  logic                fmt_xrgb,
  input  logic [PIX_IN_W-1:0] pix_in,
  output logic [15:0]         word
);
  always_comb begin
    if (fmt_xrgb) word = xrgb_to_565(pix_in);
    else          word = pix_in[15:0];
  end
endmodule

// File: rtl/dcs_pix_ser.sv
module dcs_pix_ser
  import dcs_seq_pkg::*;
#(
  parameter int CNT_W = 2 * ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CNT_W-1:0]    n_pix,
  input  logic                blank_in,
  input  logic                fmt_in,
  input  logic                en,
  input  logic                pix_valid,
  input  logic [PIX_IN_W-1:0] pix_data,
  output logic                pix_ready,
  output logic                ser_valid,
  output logic [7:0]          ser_byte,
  input  logic                out_ready,
  output logic                ser_done
);
  logic [CNT_W-1:0] left;
  logic [15:0]      hold;
  logic             full;
  logic             lo_phase;
  logic             blank_r;
  logic             fmt_r;
  logic [15:0]      conv_word;
  logic             need_px;
  logic             take;

  dcs_pix_conv u_conv (
    .fmt_xrgb (fmt_r),
    .pix_in   (pix_data),
    .word     (conv_word)
  );

  assign need_px   = en && !full && (left != '0);
  assign pix_ready = need_px && !blank_r;
  assign take      = need_px && (blank_r || pix_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left     <= '0;
      hold     <= '0;
      full     <= 1'b0;
      lo_phase <= 1'b0;
      blank_r  <= 1'b0;
      fmt_r    <= 1'b0;
    end else if (load) begin
      left     <= n_pix;
      full     <= 1'b0;
      lo_phase <= 1'b0;
      blank_r  <= blank_in;
      fmt_r    <= fmt_in;
    end else if (take) begin
      hold     <= blank_r ? 16'h0000 : conv_word;
      full     <= 1'b1;
      lo_phase <= 1'b0;
      left     <= left - CNT_W'(1);
    end else if (full && out_ready) begin
      if (lo_phase) begin
        full     <= 1'b0;
        lo_phase <= 1'b0;
      end else begin
        lo_phase <= 1'b1;
      end
    end
  end

  assign ser_valid = full;
  assign ser_byte  = lo_phase ? hold[7:0] : hold[15:8];
  assign ser_done  = full && lo_phase && out_ready && (left == '0);

  // R6: the pixel source is never pulled during a blank fill
  p_blank_no_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blank_r |-> !pix_ready);

  // R9: a stalled pixel byte keeps its word and phase
  p_ser_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready && !load) |=> full && $stable(hold) && $stable(lo_phase));

  // R6: blank pixels are all zero
  p_blank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_r && full) |-> (hold == 16'h0000));
endmodule

// File: rtl/dcs_window_seq.sv
module dcs_window_seq
  import dcs_seq_pkg::*;
#(
  parameter int SCREEN_W = 240,
  parameter int SCREEN_H = 320
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                start,
  input  logic                blank,
  input  logic                fmt_xrgb,
  input  logic [ADDR_W-1:0]   x1,
  input  logic [ADDR_W-1:0]   y1,
  input  logic [ADDR_W-1:0]   x2,
  input  logic [ADDR_W-1:0]   y2,
  input  logic                pix_valid,
  input  logic [PIX_IN_W-1:0] pix_data,
  output logic                pix_ready,
  output logic                out_valid,
  output logic                out_dc,
  output logic [7:0]          out_byte,
  input  logic                out_ready,
  output logic                busy
);
  localparam int CNT_W = 2 * ADDR_W;
  localparam logic [ADDR_W-1:0] FULL_W = ADDR_W'(SCREEN_W);
  localparam logic [ADDR_W-1:0] FULL_H = ADDR_W'(SCREEN_H);

  seq_state_e        state;
  logic [ADDR_W-1:0] rx0, ry0, rx1, ry1;
  logic [ADDR_W-1:0] ax0, ay0, ax1, ay1;
  logic              empty_r;
  logic [CNT_W-1:0]  n_pix;
  logic              accept;
  logic              hdr_ack;
  logic              hdr_last;
  tagged_byte_t      hdr;
  logic              ser_valid;
  logic [7:0]        ser_byte;
  logic              ser_done;
  logic              in_pix;

  // Event wires for the checks below.
  assign accept  = start && (state == ST_IDLE) && (enable || blank);
  assign hdr_ack = (state == ST_HDR) && out_ready;
  assign in_pix  = (state == ST_PIX);

  always_comb begin
    if (blank) begin
      ax0 = '0;     ay0 = '0;
      ax1 = FULL_W; ay1 = FULL_H;
    end else begin
      ax0 = x1; ay0 = y1;
      ax1 = x2; ay1 = y2;
    end
  end

  assign n_pix = CNT_W'(span(ax0, ax1)) * CNT_W'(span(ay0, ay1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rx0     <= '0;
      ry0     <= '0;
      rx1     <= '0;
      ry1     <= '0;
      empty_r <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_HDR;
          rx0     <= ax0;
          ry0     <= ay0;
          rx1     <= ax1;
          ry1     <= ay1;
          empty_r <= (n_pix == '0);
        end
        ST_HDR: if (hdr_ack && hdr_last) state <= empty_r ? ST_IDLE : ST_PIX;
        ST_PIX: if (ser_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  dcs_hdr_gen u_hdr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .ack   (hdr_ack),
    .cx0   (rx0),
    .cy0   (ry0),
    .cx1   (rx1),
    .cy1   (ry1),
    .hdr   (hdr),
    .last  (hdr_last)
  );

  dcs_pix_ser #(.CNT_W(CNT_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .n_pix     (n_pix),
    .blank_in  (blank),
    .fmt_in    (fmt_xrgb),
    .en        (in_pix),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_ready (pix_ready),
    .ser_valid (ser_valid),
    .ser_byte  (ser_byte),
    .out_ready (out_ready),
    .ser_done  (ser_done)
  );

  assign busy      = (state != ST_IDLE);
  assign out_valid = (state == ST_HDR) || (in_pix && ser_valid);
  assign out_dc    = (state == ST_HDR) ? hdr.dc : 1'b1;
  assign out_byte  = (state == ST_HDR) ? hdr.b  : ser_byte;

  // R1: the first byte after busy rises is the column-window opcode
  p_first_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> out_valid && !out_dc && (out_byte == OP_COL));

  // R7: non-blank starts are dropped while disabled
  p_ignore_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !enable && !blank) |=> !busy);

  // R3: payload bytes carry the data tag
  p_pix_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pix && out_valid) |-> out_dc);

  // R8: busy drops right after the last pixel byte
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_done |=> !busy);

  // R9: an offered byte is held until accepted
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_byte) && $stable(out_dc));

  // R8: the captured window does not move while busy
  p_window_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rx0) && $stable(rx1) && $stable(ry0) && $stable(ry1));
endmodule

// File: tb/tb_dcs_window_seq.sv
`timescale 1ns/1ps
module tb_dcs_window_seq;
  localparam int SW = 20;
  localparam int SH = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, start = 1'b0, blank = 1'b0, fmt_xrgb = 1'b0;
  logic [15:0] x1 = '0, y1 = '0, x2 = '0, y2 = '0;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        pix_ready, out_valid, out_dc, busy;
  logic [7:0]  out_byte;
  logic        out_ready = 1'b0;

  always #5 clk = ~clk;

  dcs_window_seq #(.SCREEN_W(SW), .SCREEN_H(SH)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .blank(blank),
    .fmt_xrgb(fmt_xrgb), .x1(x1), .y1(y1), .x2(x2), .y2(y2),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .out_valid(out_valid), .out_dc(out_dc), .out_byte(out_byte),
    .out_ready(out_ready), .busy(busy)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [8:0]  exp_mem [0:1023];
  logic [31:0] src_mem [0:255];
  int exp_n = 0, exp_idx = 0, src_idx = 0, src_n = 0;
  int rdy_pct = 100, val_pct = 100;

  task automatic check(input string req, input logic ok, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] bench_565(input logic [31:0] p, input logic xr);
    logic [4:0] r; logic [5:0] g; logic [4:0] b;
    if (!xr) return p[15:0];
    r = p[23:19]; g = p[15:10]; b = p[7:3];
    return (16'(r) << 11) | (16'(g) << 5) | 16'(b);
  endfunction

  task automatic push(input logic dc, input logic [7:0] v);
    exp_mem[exp_n] = {dc, v};
    exp_n++;
  endtask

  task automatic build(input logic [15:0] a0, input logic [15:0] b0,
                       input logic [15:0] a1, input logic [15:0] b1,
                       input logic bl, input logic xr);
    int w, h;
    logic [15:0] ea, eb, wd;
    exp_n = 0;
    ea = a1 - 16'd1; eb = b1 - 16'd1;
    push(1'b0, 8'h2A); push(1'b1, a0[15:8]); push(1'b1, a0[7:0]);
    push(1'b1, ea[15:8]); push(1'b1, ea[7:0]);
    push(1'b0, 8'h2B); push(1'b1, b0[15:8]); push(1'b1, b0[7:0]);
    push(1'b1, eb[15:8]); push(1'b1, eb[7:0]);
    push(1'b0, 8'h2C);
    w = (a1 > a0) ? int'(a1 - a0) : 0;
    h = (b1 > b0) ? int'(b1 - b0) : 0;
    src_n = bl ? 0 : w * h;
    for (int k = 0; k < w * h; k++) begin
      wd = bl ? 16'h0000 : bench_565(src_mem[k], xr);
      push(1'b1, wd[15:8]);
      push(1'b1, wd[7:0]);
    end
  endtask

  // Monitor: every accepted byte is compared in order (R1..R5).
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_idx < exp_n) begin
        check("R1/R2/R3/R4/R5 byte", {out_dc, out_byte} == exp_mem[exp_idx],
              int'({out_dc, out_byte}), int'(exp_mem[exp_idx]));
      end else begin
        check("R3 extra byte", 1'b0, int'({out_dc, out_byte}), 0);
      end
      exp_idx++;
    end
    if (rst_n && pix_valid && pix_ready) src_idx++;
  end

  // Drivers for link ready and pixel source.
  always @(posedge clk) begin
    #1;
    out_ready = ($urandom_range(99) < rdy_pct);
    if (src_idx < src_n && $urandom_range(99) < val_pct) begin
      pix_valid = 1'b1;
      pix_data  = src_mem[src_idx];
    end else begin
      pix_valid = 1'b0;
      pix_data  = $urandom;
    end
  end

  task automatic run_update(input logic [15:0] a0, input logic [15:0] b0,
                            input logic [15:0] a1, input logic [15:0] b1,
                            input logic bl, input logic xr, input logic inject);
    int cyc;
    logic [15:0] wa0, wb0, wa1, wb1;
    for (int k = 0; k < 256; k++) src_mem[k] = $urandom;
    if (bl) begin wa0 = 0; wb0 = 0; wa1 = 16'(SW); wb1 = 16'(SH); end
    else begin wa0 = a0; wb0 = b0; wa1 = a1; wb1 = b1; end
    @(negedge clk);
    src_n = 0; src_idx = 0; exp_idx = 0;
    build(wa0, wb0, wa1, wb1, bl, xr);
    @(posedge clk); #1;
    x1 = a0; y1 = b0; x2 = a1; y2 = b1; blank = bl; fmt_xrgb = xr; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    x1 = $urandom; y1 = $urandom; x2 = $urandom; y2 = $urandom; fmt_xrgb = ~xr; blank = 1'b0;
    @(negedge clk);
    check("R8 busy rises after start", busy == 1'b1, int'(busy), 1);
    cyc = 0;
    while (busy && cyc < 5000) begin
      if (inject && cyc == 4) start = 1'b1;
      if (inject && cyc == 5) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    check("R8 update finishes", cyc < 5000, cyc, 5000);
    check("R3/R8 byte count at busy fall", exp_idx == exp_n, exp_idx, exp_n);
    check("R6 pixels pulled", src_idx == src_n, src_idx, src_n);
    repeat (3) @(negedge clk);
    check("R8 quiet after finish", !busy && !out_valid, int'({busy, out_valid}), 0);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset state", !busy && !out_valid && !pix_ready,
          int'({busy, out_valid, pix_ready}), 0);

    enable = 1'b1;
    // R1/R2/R4: small native rectangle, link always ready
    run_update(16'd3, 16'd5, 16'd5, 16'd6, 1'b0, 1'b0, 1'b0);
    // R2/R5: high coordinates, XRGB, with stalls
    rdy_pct = 60; val_pct = 50;
    run_update(16'd300, 16'd511, 16'd302, 16'd513, 1'b0, 1'b1, 1'b0);
    // R3: empty rectangle, header only (bound 0 wraps)
    run_update(16'd7, 16'd2, 16'd7, 16'd0, 1'b0, 1'b0, 1'b0);
    // R8: start while busy must be ignored
    run_update(16'd1, 16'd1, 16'd4, 16'd3, 1'b0, 1'b1, 1'b1);

    // R7: non-blank start while disabled is ignored
    enable = 1'b0;
    @(posedge clk); #1;
    x1 = 0; y1 = 0; x2 = 4; y2 = 4; blank = 1'b0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R7 disabled start ignored", !busy && !out_valid, int'({busy, out_valid}), 0);
    end
    // R6/R7: blank accepted while disabled
    run_update(16'd9, 16'd9, 16'd9, 16'd9, 1'b1, 1'b0, 1'b0);

    enable = 1'b1;
    for (int t = 0; t < 25; t++) begin
      logic [15:0] a0, b0;
      a0 = 16'($urandom_range(1000));
      b0 = 16'($urandom_range(1000));
      rdy_pct = (t % 3 == 0) ? 100 : 40 + int'($urandom_range(50));
      val_pct = 30 + int'($urandom_range(70));
      run_update(a0, b0, a0 + 16'($urandom_range(1, 5)), b0 + 16'($urandom_range(1, 4)),
                 1'b0, 1'($urandom_range(1)), 1'($urandom_range(1)));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule